// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address stream for a synchronous burst memory. A full base address is captured when either of two strobes is high at a clock edge: one meant for a processor and one for a memory controller. After that edge the block walks through a four-beat burst. The upper address bits stay as they were loaded. The two lowest bits are derived from the loaded start bits and a two-bit beat count. The count steps only on edges where the advance input is high.

A run-time order input picks how the low bits are formed. In linear order the beat count is added to the start bits modulo four. In interleaved order the beat count is XORed into them. Tying the order input low gives interleaved order, which is the default. Bursts are optional: a strobe may be given on every cycle, and each one starts a fresh burst with no lost cycle.

The sequencer is a small state machine. ST_IDLE is the state after reset, before any load. ST_BEAT0, ST_BEAT1, ST_BEAT2 and ST_BEAT3 hold the beat count. The transitions are as follows. A load goes from any state to ST_BEAT0. An advance goes from ST_BEATn to ST_BEATn+1. A wrap goes from ST_BEAT3 to ST_BEAT0 on an advance. A hold keeps the present state when there is neither a strobe nor an advance, and ST_IDLE also holds on an advance alone.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_o` is all zeros and `beat_o` is 0, until the first load.
- R2: A high `strb_cpu_i` or `strb_ctl_i` at an edge loads the base address. From that edge on, `beat_o` is 0 and `addr_o` equals the `base_i` value captured at that edge.
- R3: When a burst is loaded and `adv_i` is high with no strobe, `beat_o` steps by one modulo 4 at the edge, so 3 wraps to 0. With `adv_i` low and no strobe, `beat_o` and `addr_o` keep their values.
- R4: With `order_lin_i` high, `addr_o[1:0]` equals (start low bits + `beat_o`) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R5: With `order_lin_i` low, `addr_o[1:0]` equals start low bits XOR `beat_o`. For example, a start of 1 gives 1, 0, 3, 2. The low level is the default order.
- R6: `addr_o[ADDR_W-1:2]` never changes except at a load, including across a wrap.
- R7: A strobe and `adv_i` high at the same edge act as a load only.
- R8: A strobe on consecutive edges loads a new address at every edge.
- R9: Before the first load, `adv_i` has no effect: `addr_o` and `beat_o` stay zero.
- R10: `order_lin_i` is applied without a register. A change in mid-burst alters `addr_o[1:0]` in the same cycle, and `beat_o` is left as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | ADDR_W | Base address captured at a load |
| strb_cpu_i | input | 1 | Processor-side load strobe |
| strb_ctl_i | input | 1 | Controller-side load strobe |
| adv_i | input | 1 | Step the burst by one beat |
| order_lin_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat count |

## Verification
The hardest case to reach from the ports is the wrap. The count has to come back to 0 after the last beat while the upper bits stay frozen. Getting there needs a load with non-zero upper bits followed by four advances, so the stimulus runs full four-beat bursts and compares the upper bits on every beat. A second hard case is a change of order in mid-burst. To reach it, the stimulus toggles the order input while the state sits on an odd beat, because that is where the linear and interleaved addresses differ.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } burst_state_e;
endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [BEAT_W-1:0] beat_o
);
    burst_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_BEAT0;
        end else if (adv_i) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  beat_o = 2'd0;
            ST_BEAT0: beat_o = 2'd0;
            ST_BEAT1: beat_o = 2'd1;
            ST_BEAT2: beat_o = 2'd2;
            ST_BEAT3: beat_o = 2'd3;
            default:  beat_o = 2'd0;
        endcase
    end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] base_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     base_o <= '0;
        else if (load_i) base_o <= base_i;
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  logic              lin_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] low_o
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    assign lin_low = start_i + beat_i;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_i[b] ^ beat_i[b];
    end

    assign low_o = lin_i ? lin_low : ilv_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              strb_cpu_i,
    input  logic              strb_ctl_i,
    input  logic              adv_i,
    input  logic              order_lin_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        beat_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic              load;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;

    assign load = strb_cpu_i | strb_ctl_i;

    burst_base_reg #(.ADDR_W(ADDR_W)) i_base (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .base_i (base_i),
        .base_o (base_q)
    );

    burst_seq_fsm i_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .adv_i  (adv_i),
        .beat_o (beat)
    );

    burst_order_map i_map (
        .lin_i   (order_lin_i),
        .start_i (base_q[BEAT_W-1:0]),
        .beat_i  (beat),
        .low_o   (low)
    );

    assign addr_o = {base_q[ADDR_W-1 -: UP_W], low};
    assign beat_o = beat;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] base_i,
    input logic              strb_cpu_i,
    input logic              strb_ctl_i,
    input logic              adv_i,
    input logic              order_lin_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        beat_o
);
    logic       loaded_q;
    logic [1:0] start_q;
    logic       ld;

    assign ld = strb_cpu_i | strb_ctl_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            loaded_q <= 1'b0;
            start_q  <= 2'd0;
        end else if (ld) begin
            loaded_q <= 1'b1;
            start_q  <= base_i[1:0];
        end
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld |=> (beat_o == 2'd0) && (addr_o[ADDR_W-1:2] == $past(base_i[ADDR_W-1:2]))); // R2

    AST_ADV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (loaded_q && adv_i && !ld) |=> (beat_o == $past(beat_o) + 2'd1)); // R3

    AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !ld) |=> $stable(beat_o)); // R3

    AST_LIN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (loaded_q && order_lin_i) |-> (addr_o[1:0] == 2'(start_q + beat_o))); // R4

    AST_ILV_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (loaded_q && !order_lin_i) |-> (addr_o[1:0] == (start_q ^ beat_o))); // R5

    AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld |=> $stable(addr_o[ADDR_W-1:2])); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !loaded_q |-> (addr_o == '0) && (beat_o == 2'd0)); // R9
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int  AW      = 20;
    localparam time CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] base = '0;
    logic          s_cpu = 1'b0;
    logic          s_ctl = 1'b0;
    logic          adv = 1'b0;
    logic          lin = 1'b0;
    logic [AW-1:0] addr;
    logic [1:0]    beat;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk_i(clk), .rst_ni(rst_n), .base_i(base),
        .strb_cpu_i(s_cpu), .strb_ctl_i(s_ctl), .adv_i(adv),
        .order_lin_i(lin), .addr_o(addr), .beat_o(beat)
    );

    task automatic check(input string req, input logic [AW-1:0] exp_a, input logic [1:0] exp_b);
        n_chk++;
        if (addr !== exp_a || beat !== exp_b) begin
            n_bad++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d", req, addr, beat, exp_a, exp_b);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, logic [1:0] k, logic l);
        logic [1:0] s = b[1:0];
        return {b[AW-1:2], (l ? 2'(s + k) : (s ^ k))};
    endfunction

    task automatic do_load(input logic [AW-1:0] b, input bit use_ctl);
        base = b; s_cpu = !use_ctl; s_ctl = use_ctl;
        tick();
        s_cpu = 0; s_ctl = 0;
    endtask

    task automatic t_reset_idle();
        check("R1", '0, 2'd0);
        adv = 1; tick(); tick(); adv = 0;
        check("R9", '0, 2'd0);
    endtask

    task automatic t_burst(input logic [AW-1:0] b, input logic l, input bit use_ctl, input string req);
        lin = l;
        do_load(b, use_ctl);
        check("R2", b, 2'd0);
        for (int k = 1; k <= 4; k++) begin
            adv = 1; tick(); adv = 0;
            check(req, expect_addr(b, 2'(k), l), 2'(k));
            check("R6", {b[AW-1:2], addr[1:0]}, beat);
        end
        tick();
        check("R3", expect_addr(b, 2'd0, l), 2'd0);
    endtask

    task automatic t_priority();
        lin = 0;
        do_load(20'h12341, 0);
        adv = 1; tick();
        base = 20'hABCD2; s_ctl = 1; tick(); s_ctl = 0; adv = 0;
        check("R7", 20'hABCD2, 2'd0);
    endtask

    task automatic t_back_to_back();
        for (int i = 0; i < 4; i++) begin
            base = 20'h55550 + 20'(i * 5); s_cpu = (i % 2 == 0); s_ctl = (i % 2 == 1);
            tick();
            check("R8", 20'h55550 + 20'(i * 5), 2'd0);
        end
        s_cpu = 0; s_ctl = 0;
    endtask

    task automatic t_mode_switch();
        lin = 1;
        do_load(20'h0F0F1, 0);
        adv = 1; tick(); adv = 0;
        check("R10", expect_addr(20'h0F0F1, 2'd1, 1'b1), 2'd1);
        lin = 0; #1;
        check("R10", expect_addr(20'h0F0F1, 2'd1, 1'b0), 2'd1);
        lin = 1; #1;
        check("R10", expect_addr(20'h0F0F1, 2'd1, 1'b1), 2'd1);
    endtask

    initial begin
        #(CLK_PER * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PER * 2 + 1);
        t_reset_idle();
        rst_n = 1;
        tick();
        t_reset_idle();
        t_burst(20'hA5F32, 1'b1, 0, "R4");
        t_burst(20'h3C6A1, 1'b0, 1, "R5");
        t_burst(20'hFFFF2, 1'b0, 0, "R5");
        t_burst(20'h80003, 1'b1, 1, "R4");
        t_priority();
        t_back_to_back();
        t_mode_switch();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule